// File: doc/BRIEF.md
# Fault Logging and Alert Controller

This block keeps the fault record for a hot-swap power switch. Two hardware conditions are watched. The first is a shorted switch, where current flows while the gate is off. The second is a sagging output, where feedback stays low while the gate is on. Each condition drives a live status bit and a sticky fault bit. Software reads and edits the registers through a small synchronous register port. A bus interface reports Alert Response Address cycles and direct-address hits on two strobes.

The alert output is active low and behaves like an open-drain line. Only fault bits enabled in the mask register can pull it low. A release leaves it high until the fault picture really changes: a fault bit appears that was not set at the last release, or a bit is cleared and then set again. Unplugging and replugging a load card clears most of the record. After a settling delay, the level of the ON input is copied into the run bit of the control register, and that bit drives the restart request.

Top module: `fault_alert_ctrl`

## Requirements
- R1: After synchronous reset the control, mask, fault and status registers read zero, `alert_n` is 1, `pgood` is 1 and `restart_req` is 0. The read address selects control (0), mask (1), fault (2) or status (3). `rd_data` shows the selected register one clock after the address is applied.
- R2: A fault bit can pull `alert_n` low only if the same bit is set in the mask register. `alert_n` falls on the clock after a bit becomes both set and enabled. This includes a fault already set when its mask bit is written.
- R3: A one-cycle pulse on `ara_ack` or `addr_hit` drives `alert_n` high on the next clock.
- R4: After a release, a fault that persists, or that keeps being set again without being cleared, leaves `alert_n` high. A different enabled fault bit, or an enabled bit that was cleared and then set again, pulls it low.
- R5: A write to the fault register loads the written value, so writing 0 to a bit clears it. If a hardware set of a bit coincides with a write clearing that bit, the bit ends up set.
- R6: A falling edge on `on_in` clears the whole fault register.
- R7: While `isense_hi` is 1 and `gate_on` is 0, status bit 5 and fault bit 5 are set on the next clock. Status bit 5 follows the condition live.
- R8: Power-bad is declared after `fb_low`, `gate_on` and `gs_ok` have all been 1 for PBAD_CYC consecutive clocks. On that clock status bit 3 sets and `pgood` goes low. Fault bit 3 sets one clock later. Power-bad is never declared while `gs_ok` is 0.
- R9: When the power-bad condition goes away, status bit 3 clears and `pgood` returns high on the next clock. Fault bit 3 stays set.
- R10: A rising edge on `en_in` clears every fault bit except bit 4.
- R11: INS_CYC+1 clocks after the rising edge of `en_in`, control bit 3 takes the level of `on_in`, and `restart_req` follows control bit 3. If `en_in` falls before the count completes, the load is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| isense_hi | input | 1 | Current-sense reading at or above the short threshold |
| fb_low | input | 1 | Feedback comparator below its threshold |
| gate_on | input | 1 | Switch gate is driven on |
| gs_ok | input | 1 | Gate-to-source drive is adequate |
| en_in | input | 1 | Card-present level |
| on_in | input | 1 | Switch on command level |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | REG_W | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | REG_W | Registered readback |
| ara_ack | input | 1 | Device answered an Alert Response Address cycle |
| addr_hit | input | 1 | Device addressed directly by the bus master |
| alert_n | output | 1 | Active-low alert, 1 means released |
| pgood | output | 1 | Power-good, 0 means pulled low |
| restart_req | output | 1 | Restart request from control bit 3 |

## Verification
The alert path is driven four ways. A fault that exists before its mask bit is written shows that enabling an existing fault raises the alert. A fault held across a release shows that a persisting fault does not raise it again. A second fault of a different kind pulls the line low, while a clear followed by the same fault re-arms it, which together show that re-arming follows bit history rather than activity. The power-bad filter gets a burst one cycle short of the limit, a burst that reaches it, and a long burst with weak gate drive. The insertion timer gets a full count and an interrupted count, which separates the restart load from card removal.

// File: rtl/fault_alert_pkg.sv
package fault_alert_pkg;
  typedef enum logic [1:0] {
    RA_CTRL  = 2'd0,
    RA_MASK  = 2'd1,
    RA_FAULT = 2'd2,
    RA_STAT  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/fa_pbad_filter.sv
module fa_pbad_filter #(
  parameter int LIM = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic cond,
  output logic bad
);
  localparam int CW = (LIM > 1) ? $clog2(LIM) : 1;

  logic [CW-1:0] cnt;

  // counts consecutive qualified cycles; the flag drops as soon as the condition does
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      bad <= 1'b0;
    end else if (!cond) begin
      cnt <= '0;
      bad <= 1'b0;
    end else if (!bad) begin
      if (cnt == CW'(LIM - 1)) bad <= 1'b1;
      else                     cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/fa_insert_timer.sv
module fa_insert_timer #(
  parameter int CYC = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic en_level,
  input  logic rise,
  output logic load_pulse
);
  localparam int CW = $clog2(CYC + 1);

  logic          run;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      run        <= 1'b0;
      cnt        <= '0;
      load_pulse <= 1'b0;
    end else begin
      load_pulse <= 1'b0;
      if (rise) begin
        run <= 1'b1;
        cnt <= '0;
      end else if (run) begin
        if (!en_level) begin
          run <= 1'b0;
        end else if (cnt == CW'(CYC - 1)) begin
          load_pulse <= 1'b1;
          run        <= 1'b0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/fa_alert_track.sv
module fa_alert_track #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] armed,
  input  logic         release_i,
  output logic         alert_n
);
  logic [W-1:0] snap;
  logic         raised;

  // snap holds the enabled faults seen at the last release; cleared bits drop out of it
  always_ff @(posedge clk) begin
    if (rst) begin
      snap   <= '0;
      raised <= 1'b0;
    end else if (release_i) begin
      raised <= 1'b0;
      snap   <= armed;
    end else begin
      snap <= snap & armed;
      if (|(armed & ~snap)) raised <= 1'b1;
    end
  end

  assign alert_n = ~raised;
endmodule

// File: rtl/fault_alert_ctrl.sv
module fault_alert_ctrl
  import fault_alert_pkg::*;
#(
  parameter int REG_W     = 8,
  parameter int SHORT_BIT = 5,
  parameter int PBAD_BIT  = 3,
  parameter int KEEP_BIT  = 4,
  parameter int RUN_BIT   = 3,
  parameter int CLK_KHZ   = 100000,
  parameter int PBAD_US   = 2,
  parameter int INS_MS    = 100
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             isense_hi,
  input  logic             fb_low,
  input  logic             gate_on,
  input  logic             gs_ok,
  input  logic             en_in,
  input  logic             on_in,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [REG_W-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  output logic [REG_W-1:0] rd_data,
  input  logic             ara_ack,
  input  logic             addr_hit,
  output logic             alert_n,
  output logic             pgood,
  output logic             restart_req
);
  localparam int PBAD_RAW = (CLK_KHZ * PBAD_US + 999) / 1000;
  localparam int PBAD_CYC = (PBAD_RAW < 1) ? 1 : PBAD_RAW;
  localparam int INS_CYC  = CLK_KHZ * INS_MS;
  localparam logic [REG_W-1:0] KEEP_MASK = REG_W'(1) << KEEP_BIT;

  logic [REG_W-1:0] ctrl_q, mask_q, fault_q, fault_nx, hw_set, stat_v;
  logic             on_d, en_d, short_q, pbad_q, load_pulse;
  logic             short_now, on_fall, en_rise, wr_fault, pbad_cond;

  assign short_now = isense_hi & ~gate_on;
  assign pbad_cond = fb_low & gate_on & gs_ok;
  assign on_fall   = on_d & ~on_in;
  assign en_rise   = ~en_d & en_in;
  assign wr_fault  = wr_en && (wr_addr == RA_FAULT);

  always_comb begin
    hw_set            = '0;
    hw_set[SHORT_BIT] = short_now;
    hw_set[PBAD_BIT]  = pbad_q;
    stat_v            = '0;
    stat_v[SHORT_BIT] = short_q;
    stat_v[PBAD_BIT]  = pbad_q;
  end

  // per-bit next state: clears, then software load, then hardware set on top
  for (genvar g = 0; g < REG_W; g++) begin : g_fault
    assign fault_nx[g] = hw_set[g] |
      (wr_fault ? wr_data[g]
                : (fault_q[g] & ~on_fall & ~(en_rise & ~KEEP_MASK[g])));
  end

  fa_pbad_filter #(.LIM(PBAD_CYC)) u_pbad (
    .clk  (clk),
    .rst  (rst),
    .cond (pbad_cond),
    .bad  (pbad_q)
  );

  fa_insert_timer #(.CYC(INS_CYC)) u_ins (
    .clk        (clk),
    .rst        (rst),
    .en_level   (en_in),
    .rise       (en_rise),
    .load_pulse (load_pulse)
  );

  fa_alert_track #(.W(REG_W)) u_alert (
    .clk       (clk),
    .rst       (rst),
    .armed     (fault_q & mask_q),
    .release_i (ara_ack | addr_hit),
    .alert_n   (alert_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      mask_q  <= '0;
      fault_q <= '0;
      short_q <= 1'b0;
      on_d    <= 1'b0;
      en_d    <= 1'b0;
    end else begin
      on_d    <= on_in;
      en_d    <= en_in;
      short_q <= short_now;
      fault_q <= fault_nx;
      if (wr_en && wr_addr == RA_MASK) mask_q <= wr_data;
      if (wr_en && wr_addr == RA_CTRL) ctrl_q <= wr_data;
      if (load_pulse) ctrl_q[RUN_BIT] <= on_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      unique case (reg_addr_e'(rd_addr))
        RA_CTRL:  rd_data <= ctrl_q;
        RA_MASK:  rd_data <= mask_q;
        RA_FAULT: rd_data <= fault_q;
        RA_STAT:  rd_data <= stat_v;
      endcase
    end
  end

  assign pgood       = ~pbad_q;
  assign restart_req = ctrl_q[RUN_BIT];
endmodule

// File: rtl/fa_chk.sv
module fa_chk #(
  parameter int REG_W     = 8,
  parameter int SHORT_BIT = 5,
  parameter int PBAD_BIT  = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             isense_hi,
  input logic             gate_on,
  input logic             fb_low,
  input logic             gs_ok,
  input logic             on_in,
  input logic             wr_en,
  input logic             ara_ack,
  input logic             addr_hit,
  input logic             alert_n,
  input logic             pgood,
  input logic [REG_W-1:0] fault_q,
  input logic [REG_W-1:0] mask_q,
  input logic [REG_W-1:0] stat_v
);
  assert_mask_gate_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(alert_n) |-> $past((fault_q & mask_q) != '0));

  assert_release_R3: assert property (@(posedge clk) disable iff (rst)
    (ara_ack || addr_hit) |=> alert_n);

  assert_short_set_R7: assert property (@(posedge clk) disable iff (rst)
    (isense_hi && !gate_on) |=> (fault_q[SHORT_BIT] && stat_v[SHORT_BIT]));

  assert_pbad_qual_R8: assert property (@(posedge clk) disable iff (rst)
    (!gs_ok || !gate_on || !fb_low) |=> (!stat_v[PBAD_BIT] && pgood));

  assert_on_clear_R6: assert property (@(posedge clk) disable iff (rst)
    ($fell(on_in) && !wr_en && !(isense_hi && !gate_on) && !stat_v[PBAD_BIT])
      |=> (fault_q == '0));
endmodule

bind fault_alert_ctrl fa_chk #(
  .REG_W(REG_W), .SHORT_BIT(SHORT_BIT), .PBAD_BIT(PBAD_BIT)
) u_chk (
  .clk(clk), .rst(rst), .isense_hi(isense_hi), .gate_on(gate_on),
  .fb_low(fb_low), .gs_ok(gs_ok), .on_in(on_in), .wr_en(wr_en),
  .ara_ack(ara_ack), .addr_hit(addr_hit), .alert_n(alert_n),
  .pgood(pgood), .fault_q(fault_q), .mask_q(mask_q), .stat_v(stat_v)
);

// File: tb/fault_alert_ctrl_tb.sv
module fault_alert_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LIM = 4;
  localparam int INS = 2000;

  logic       clk = 0, rst = 1;
  logic       isense_hi = 0, fb_low = 0, gate_on = 0, gs_ok = 0, en_in = 0, on_in = 0;
  logic       wr_en = 0, ara_ack = 0, addr_hit = 0;
  logic [1:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic       alert_n, pgood, restart_req;

  int nchk = 0, nerr = 0;
  bit live = 0;

  // reference model state
  logic [7:0] m_ctrl, m_mask, m_fault, m_stat, m_snap, m_rd;
  bit m_alert, m_bad, m_on_d, m_en_d, m_run, m_pulse;
  int m_pcnt, m_tmr;

  always #(CLK_PERIOD/2) clk = ~clk;

  fault_alert_ctrl #(.CLK_KHZ(2000), .PBAD_US(2), .INS_MS(1)) u_dut (
    .clk(clk), .rst(rst), .isense_hi(isense_hi), .fb_low(fb_low),
    .gate_on(gate_on), .gs_ok(gs_ok), .en_in(en_in), .on_in(on_in),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ara_ack(ara_ack),
    .addr_hit(addr_hit), .alert_n(alert_n), .pgood(pgood),
    .restart_req(restart_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    logic [7:0] hw, nf, armed;
    bit sn;
    if (rst) begin
      m_ctrl = 0; m_mask = 0; m_fault = 0; m_stat = 0; m_snap = 0; m_rd = 0;
      m_alert = 0; m_bad = 0; m_on_d = 0; m_en_d = 0; m_run = 0; m_pulse = 0;
      m_pcnt = 0; m_tmr = 0;
    end else begin
      sn = isense_hi && !gate_on;
      hw = 0; hw[5] = sn; hw[3] = m_bad;
      armed = m_fault & m_mask;
      case (rd_addr)
        2'd0: m_rd = m_ctrl;
        2'd1: m_rd = m_mask;
        2'd2: m_rd = m_fault;
        default: m_rd = m_stat;
      endcase
      nf = m_fault;
      if (m_on_d && !on_in) nf = 0;
      if (!m_en_d && en_in) nf = nf & 8'h10;
      if (wr_en && wr_addr == 2'd2) nf = wr_data;
      nf = nf | hw;
      if (ara_ack || addr_hit) begin m_alert = 0; m_snap = armed; end
      else begin
        if ((armed & ~m_snap) != 0) m_alert = 1;
        m_snap = m_snap & armed;
      end
      if (wr_en && wr_addr == 2'd0) m_ctrl = wr_data;
      if (m_pulse) m_ctrl[3] = on_in;
      m_pulse = 0;
      if (!m_en_d && en_in) begin m_run = 1; m_tmr = 0; end
      else if (m_run) begin
        if (!en_in) m_run = 0;
        else begin
          m_tmr++;
          if (m_tmr == INS) begin m_pulse = 1; m_run = 0; end
        end
      end
      if (wr_en && wr_addr == 2'd1) m_mask = wr_data;
      if (!(fb_low && gate_on && gs_ok)) begin m_pcnt = 0; m_bad = 0; end
      else if (!m_bad) begin
        m_pcnt++;
        if (m_pcnt == LIM) m_bad = 1;
      end
      m_stat = 0; m_stat[5] = sn; m_stat[3] = m_bad;
      m_fault = nf; m_on_d = on_in; m_en_d = en_in;
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (live) begin
      chk("R4 alert_n vs model", alert_n, !m_alert);
      chk("R8 pgood vs model", pgood, !m_bad);
      chk("R11 restart_req vs model", restart_req, m_ctrl[3]);
      chk("R5 rd_data vs model", rd_data, m_rd);
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    rd_addr = a;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic pulse_ara();
    ara_ack = 1; @(negedge clk); ara_ack = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nerr++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [7:0] v;
    cyc(4);
    rst = 0;
    live = 1;
    // R1 reset state
    chk("R1 alert_n", alert_n, 1);
    chk("R1 pgood", pgood, 1);
    chk("R1 restart_req", restart_req, 0);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      chk("R1 register zero", v, 0);
    end
    // R7 short sets status and fault; R2 mask blocks alert
    isense_hi = 1; cyc(1);
    rd(2'd3, v); chk("R7 status short", v, 8'h20);
    isense_hi = 0; cyc(2);
    rd(2'd2, v); chk("R7 fault short", v, 8'h20);
    chk("R2 masked off", alert_n, 1);
    wr(2'd1, 8'h20); cyc(1);
    chk("R2 enable existing fault", alert_n, 0);
    // R3 release by ARA
    pulse_ara();
    chk("R3 ara release", alert_n, 1);
    // R4 persisting fault
    isense_hi = 1; cyc(3);
    chk("R4 persist no alert", alert_n, 1);
    isense_hi = 0; cyc(1);
    chk("R4 persist no alert after", alert_n, 1);
    // R8 power-bad filter
    wr(2'd1, 8'h28);
    gate_on = 1; gs_ok = 1; fb_low = 1; cyc(LIM - 1);
    fb_low = 0; cyc(1);
    rd(2'd3, v); chk("R8 short burst ignored", v, 0);
    chk("R8 pgood after short burst", pgood, 1);
    fb_low = 1; cyc(LIM);
    chk("R8 pgood low", pgood, 0);
    cyc(2);
    chk("R4 different fault alerts", alert_n, 0);
    rd(2'd3, v); chk("R8 status pbad", v, 8'h08);
    // R9 recovery
    fb_low = 0; cyc(1);
    chk("R9 pgood back", pgood, 1);
    rd(2'd3, v); chk("R9 status cleared", v, 0);
    rd(2'd2, v); chk("R9 fault sticky", v, 8'h28);
    // R8 weak gate drive suppresses
    gs_ok = 0; fb_low = 1; cyc(8);
    chk("R8 suppressed by gs_ok", pgood, 1);
    fb_low = 0; gs_ok = 1;
    // R3 release by address hit
    addr_hit = 1; cyc(1); addr_hit = 0;
    chk("R3 addr_hit release", alert_n, 1);
    // R4 clear then set again re-arms
    wr(2'd2, 8'h08);
    gate_on = 0; cyc(1);
    isense_hi = 1; cyc(1);
    isense_hi = 0; cyc(1);
    chk("R4 re-armed alert", alert_n, 0);
    pulse_ara();
    // R5 hardware set beats write clear; write loads value
    isense_hi = 1;
    wr(2'd2, 8'h00);
    isense_hi = 0;
    rd(2'd2, v); chk("R5 hw set wins", v, 8'h20);
    wr(2'd2, 8'h12);
    rd(2'd2, v); chk("R5 write loads", v, 8'h12);
    // R6 ON falling edge clears
    on_in = 1; cyc(2);
    on_in = 0; cyc(1);
    rd(2'd2, v); chk("R6 on fall clears", v, 0);
    // R10 insertion clear, R11 timed restart
    wr(2'd0, 8'h00);
    on_in = 1; cyc(1);
    wr(2'd2, 8'h3A);
    en_in = 1; cyc(1);
    rd(2'd2, v); chk("R10 keep bit 4 only", v, 8'h10);
    cyc(INS - 2);
    chk("R11 not yet", restart_req, 0);
    cyc(1);
    chk("R11 still not yet", restart_req, 0);
    cyc(1);
    chk("R11 restart latched", restart_req, 1);
    // R11 abort on removal
    wr(2'd0, 8'h00);
    en_in = 0; cyc(1);
    en_in = 1; cyc(INS / 2);
    en_in = 0; cyc(INS);
    chk("R11 abort no restart", restart_req, 0);
    live = 0;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule